// File: doc/BRIEF.md
# Banked Frame Store with Two-by-Two Neighbour Fetch

This block holds one grayscale frame in on-chip memory and serves the pixel fetches of a geometric remapping pipeline. A raster pixel stream is written into the store. The first pixel of a frame is marked by a write sync. A coordinate mapper then presents one integer source coordinate per cycle, together with its fractional offsets. One cycle later the block returns the four pixels that surround that coordinate. The fractions, a read sync marker and a valid flag travel alongside, so a bilinear interpolator can combine them directly.

The frame is split across four banks by row parity and column parity. A two-by-two window at any position then touches each bank exactly once, and a full window is read in a single cycle at an arbitrary address. A neighbour that would fall beyond the last column or the last row is replaced by the edge pixel.

The write side is a two-state machine. `WS_IDLE` waits for a pixel that carries the write sync. That pixel moves the machine to `WS_STORE` and is stored at the origin. In `WS_STORE`, every valid pixel advances the raster position. The last pixel of the frame returns the machine to `WS_IDLE`. A sync pixel seen in `WS_STORE` restarts the frame at the origin and keeps the machine in `WS_STORE`.

Top module: `quad_window_fb`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_sync` are low.
- R2: Starting at the pixel that carries `wr_sync`, valid pixels are stored in raster order: column 0 to FRAME_W-1 within a row, then rows 0 to FRAME_H-1. Cycles with `wr_valid` low store nothing and do not advance the position.
- R3: After the last pixel of a frame, valid pixels without `wr_sync` are discarded and leave the stored frame unchanged.
- R4: For a read of in-range coordinate (x,y), the outputs in the following cycle are: `out_p00`=(x,y), `out_p10`=(x+1,y), `out_p01`=(x,y+1), `out_p11`=(x+1,y+1).
- R5: When x equals FRAME_W-1, the x+1 neighbours are replaced by column FRAME_W-1.
- R6: When y equals FRAME_H-1, the y+1 neighbours are replaced by row FRAME_H-1. At the bottom-right corner, all four outputs equal that corner pixel.
- R7: `out_fx`, `out_fy` and `out_sync` equal the `rd_fx`, `rd_fy` and `rd_sync` of the read they belong to, and appear in the same cycle as its pixels.
- R8: `out_valid` is high exactly in the cycle after a cycle with `rd_valid` high. Back-to-back reads give one result per cycle.
- R9: A `wr_sync` pixel arriving in the middle of a frame restarts storage at the origin. The following pixels continue from column 1 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sync | input | 1 | Marks the first pixel of a frame |
| wr_valid | input | 1 | Write pixel strobe |
| wr_pix | input | PIX_W | Incoming grayscale pixel |
| rd_sync | input | 1 | Marks the first coordinate of an output frame |
| rd_valid | input | 1 | Read strobe |
| rd_x | input | clog2(FRAME_W) | Integer source column |
| rd_y | input | clog2(FRAME_H) | Integer source row |
| rd_fx | input | FRAC_W | Column fraction, passed through |
| rd_fy | input | FRAC_W | Row fraction, passed through |
| out_valid | output | 1 | Window result valid |
| out_sync | output | 1 | Delayed read sync |
| out_fx | output | FRAC_W | Delayed column fraction |
| out_fy | output | FRAC_W | Delayed row fraction |
| out_p00 | output | PIX_W | Pixel (x,y) |
| out_p10 | output | PIX_W | Pixel (x+1,y), clamped |
| out_p01 | output | PIX_W | Pixel (x,y+1), clamped |
| out_p11 | output | PIX_W | Pixel (x+1,y+1), clamped |

## Verification
The bench builds the block with its defaults: a 64 by 32 frame, 8-bit pixels and 4-bit fractions. With these values every one of the 2048 coordinates can be read back, twice, with two different frame contents, in a few thousand cycles. This covers the clamped right column, the clamped bottom row and the corner. It also covers every combination of bank parities for the four neighbours. The small frame also makes it cheap to write an aborted partial frame, a restart and a tail of unsynced pixels before each sweep.

// File: rtl/quadfb_pkg.sv
package quadfb_pkg;

    typedef enum logic [0:0] {
        WS_IDLE  = 1'b0,
        WS_STORE = 1'b1
    } wr_state_e;

    // linear word index inside one parity bank
    function automatic int unsigned bank_word(input int unsigned half_col,
                                              input int unsigned half_row,
                                              input int unsigned half_w);
        return half_row * half_w + half_col;
    endfunction

endpackage

// File: rtl/quadfb_bank.sv
module quadfb_bank #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/quadfb_wr_ctrl.sv
module quadfb_wr_ctrl
    import quadfb_pkg::*;
#(
    parameter int FRAME_W = 64,
    parameter int FRAME_H = 32,
    parameter int PIX_W   = 8,
    parameter int XW      = $clog2(FRAME_W),
    parameter int YW      = $clog2(FRAME_H),
    parameter int BAW     = $clog2((FRAME_W / 2) * (FRAME_H / 2))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sync,
    input  logic             wr_valid,
    input  logic [PIX_W-1:0] wr_pix,
    output logic             bank_we,
    output logic [1:0]       bank_sel,
    output logic [BAW-1:0]   bank_waddr,
    output logic [PIX_W-1:0] bank_wdata
);

    localparam int unsigned HALF_W = FRAME_W / 2;
    localparam logic [XW-1:0] LAST_X = XW'(FRAME_W - 1);
    localparam logic [YW-1:0] LAST_Y = YW'(FRAME_H - 1);

    wr_state_e     state_q, state_d;
    logic [XW-1:0] col_q, col_d;
    logic [YW-1:0] row_q, row_d;
    logic          start, go, last;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    always_comb begin
        start   = wr_valid && wr_sync;
        go      = 1'b0;
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  go = start;
            WS_STORE: go = wr_valid;
            default:  go = 1'b0;
        endcase
        cur_x = start ? '0 : col_q;
        cur_y = start ? '0 : row_q;
        last  = (cur_x == LAST_X) && (cur_y == LAST_Y);
        col_d = col_q;
        row_d = row_q;
        if (go) begin
            if (last) begin
                state_d = WS_IDLE;
                col_d   = '0;
                row_d   = '0;
            end else begin
                state_d = WS_STORE;
                if (cur_x == LAST_X) begin
                    col_d = '0;
                    row_d = cur_y + 1'b1;
                end else begin
                    col_d = cur_x + 1'b1;
                    row_d = cur_y;
                end
            end
        end
    end

    always_comb begin
        bank_we    = go;
        bank_sel   = {cur_y[0], cur_x[0]};
        bank_waddr = BAW'(bank_word(int'(cur_x >> 1), int'(cur_y >> 1), HALF_W));
        bank_wdata = wr_pix;
    end

    p_pos_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_STORE) |-> (col_q <= LAST_X && row_q <= LAST_Y));

    p_origin_on_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE) |-> (col_q == '0 && row_q == '0));

    p_idle_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE && !wr_sync) |-> !bank_we);

    p_sync_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sync) |=> (state_q == WS_STORE && col_q == XW'(1) && row_q == '0));

endmodule

// File: rtl/quadfb_rd_addr.sv
module quadfb_rd_addr
    import quadfb_pkg::*;
#(
    parameter int FRAME_W = 64,
    parameter int FRAME_H = 32,
    parameter int XW      = $clog2(FRAME_W),
    parameter int YW      = $clog2(FRAME_H),
    parameter int BAW     = $clog2((FRAME_W / 2) * (FRAME_H / 2))
) (
    input  logic [XW-1:0]        rd_x,
    input  logic [YW-1:0]        rd_y,
    output logic [3:0][BAW-1:0]  raddr,
    output logic [3:0]           par   // {y1,y0,x1,x0} parities
);

    localparam int unsigned HALF_W = FRAME_W / 2;
    localparam logic [XW-1:0] LAST_X = XW'(FRAME_W - 1);
    localparam logic [YW-1:0] LAST_Y = YW'(FRAME_H - 1);

    logic [XW-1:0] x0, x1;
    logic [YW-1:0] y0, y1;

    always_comb begin
        x0  = rd_x;
        y0  = rd_y;
        x1  = (rd_x == LAST_X) ? rd_x : rd_x + 1'b1;
        y1  = (rd_y == LAST_Y) ? rd_y : rd_y + 1'b1;
        par = {y1[0], y0[0], x1[0], x0[0]};
    end

    for (genvar b = 0; b < 4; b++) begin : g_bank_addr
        localparam logic PC = logic'(b % 2);
        localparam logic PR = logic'(b / 2);
        logic [XW-1:0] cx;
        logic [YW-1:0] cy;
        always_comb begin
            cx       = (x0[0] == PC) ? x0 : x1;
            cy       = (y0[0] == PR) ? y0 : y1;
            raddr[b] = BAW'(bank_word(int'(cx >> 1), int'(cy >> 1), HALF_W));
        end
    end

endmodule

// File: rtl/quad_window_fb.sv
module quad_window_fb #(
    parameter int FRAME_W = 64,
    parameter int FRAME_H = 32,
    parameter int PIX_W   = 8,
    parameter int FRAC_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_sync,
    input  logic                         wr_valid,
    input  logic [PIX_W-1:0]             wr_pix,
    input  logic                         rd_sync,
    input  logic                         rd_valid,
    input  logic [$clog2(FRAME_W)-1:0]   rd_x,
    input  logic [$clog2(FRAME_H)-1:0]   rd_y,
    input  logic [FRAC_W-1:0]            rd_fx,
    input  logic [FRAC_W-1:0]            rd_fy,
    output logic                         out_valid,
    output logic                         out_sync,
    output logic [FRAC_W-1:0]            out_fx,
    output logic [FRAC_W-1:0]            out_fy,
    output logic [PIX_W-1:0]             out_p00,
    output logic [PIX_W-1:0]             out_p10,
    output logic [PIX_W-1:0]             out_p01,
    output logic [PIX_W-1:0]             out_p11
);

    localparam int XW    = $clog2(FRAME_W);
    localparam int YW    = $clog2(FRAME_H);
    localparam int DEPTH = (FRAME_W / 2) * (FRAME_H / 2);
    localparam int BAW   = $clog2(DEPTH);

    logic                    bank_we;
    logic [1:0]              bank_sel;
    logic [BAW-1:0]          bank_waddr;
    logic [PIX_W-1:0]        bank_wdata;
    logic [3:0][BAW-1:0]     raddr;
    logic [3:0]              par;
    logic [3:0][PIX_W-1:0]   bank_q;
    logic [3:0]              par_q;

    quadfb_wr_ctrl #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .PIX_W(PIX_W),
        .XW(XW), .YW(YW), .BAW(BAW)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_sync(wr_sync), .wr_valid(wr_valid), .wr_pix(wr_pix),
        .bank_we(bank_we), .bank_sel(bank_sel),
        .bank_waddr(bank_waddr), .bank_wdata(bank_wdata)
    );

    quadfb_rd_addr #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
        .XW(XW), .YW(YW), .BAW(BAW)
    ) u_rd (
        .rd_x(rd_x), .rd_y(rd_y), .raddr(raddr), .par(par)
    );

    for (genvar b = 0; b < 4; b++) begin : g_bank
        quadfb_bank #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(BAW)) u_bank (
            .clk(clk),
            .we(bank_we && (bank_sel == 2'(b))),
            .waddr(bank_waddr),
            .wdata(bank_wdata),
            .raddr(raddr[b]),
            .rdata(bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sync  <= 1'b0;
            out_fx    <= '0;
            out_fy    <= '0;
            par_q     <= '0;
        end else begin
            out_valid <= rd_valid;
            out_sync  <= rd_valid && rd_sync;
            out_fx    <= rd_fx;
            out_fy    <= rd_fy;
            par_q     <= par;
        end
    end

    always_comb begin
        out_p00 = bank_q[{par_q[2], par_q[0]}];
        out_p10 = bank_q[{par_q[2], par_q[1]}];
        out_p01 = bank_q[{par_q[3], par_q[0]}];
        out_p11 = bank_q[{par_q[3], par_q[1]}];
    end

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);

    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);

    p_frac_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (out_fx == $past(rd_fx) && out_fy == $past(rd_fy)));

    p_right_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_x == XW'(FRAME_W - 1)) |=> (out_p10 == out_p00 && out_p11 == out_p01));

    p_bottom_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_y == YW'(FRAME_H - 1)) |=> (out_p01 == out_p00 && out_p11 == out_p10));

endmodule

// File: tb/quad_window_fb_bench.sv
`timescale 1ns/1ps
module quad_window_fb_bench;

    localparam int W  = 64;
    localparam int H  = 32;
    localparam int PW = 8;
    localparam int FW = 4;
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_sync = 1'b0, wr_valid = 1'b0;
    logic [PW-1:0] wr_pix = '0;
    logic          rd_sync = 1'b0, rd_valid = 1'b0;
    logic [XW-1:0] rd_x = '0;
    logic [YW-1:0] rd_y = '0;
    logic [FW-1:0] rd_fx = '0, rd_fy = '0;
    logic          out_valid, out_sync;
    logic [FW-1:0] out_fx, out_fy;
    logic [PW-1:0] out_p00, out_p10, out_p01, out_p11;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    quad_window_fb #(.FRAME_W(W), .FRAME_H(H), .PIX_W(PW), .FRAC_W(FW)) u_quad_window_fb (
        .clk(clk), .rst_n(rst_n),
        .wr_sync(wr_sync), .wr_valid(wr_valid), .wr_pix(wr_pix),
        .rd_sync(rd_sync), .rd_valid(rd_valid), .rd_x(rd_x), .rd_y(rd_y),
        .rd_fx(rd_fx), .rd_fy(rd_fy),
        .out_valid(out_valid), .out_sync(out_sync), .out_fx(out_fx), .out_fy(out_fy),
        .out_p00(out_p00), .out_p10(out_p10), .out_p01(out_p01), .out_p11(out_p11)
    );

    function automatic int pix(int x, int y, int seed);
        return (x * 5 + y * 11 + x * y + seed * 29) & 255;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(bit s, int v);
        wr_valid = 1'b1;
        wr_sync  = s;
        wr_pix   = PW'(v);
        @(negedge clk);
        wr_valid = 1'b0;
        wr_sync  = 1'b0;
    endtask

    task automatic write_frame(int seed);
        for (int i = 0; i < W * H; i++) begin
            put(i == 0, pix(i % W, i / W, seed));
            if (i % 7 == 3) begin
                wr_pix = 8'hAA;          // idle cycle, must not store (R2)
                @(negedge clk);
            end
        end
    endtask

    task automatic check_window(int x, int y, bit s, int seed);
        int x1, y1;
        string tag;
        int act, exp;
        x1 = (x == W - 1) ? x : x + 1;
        y1 = (y == H - 1) ? y : y + 1;
        tag = (y == H - 1) ? "R6" : ((x == W - 1) ? "R5" : "R4");
        act = {out_p00, out_p10, out_p01, out_p11};
        exp = (pix(x, y, seed) << 24) | (pix(x1, y, seed) << 16)
            | (pix(x, y1, seed) << 8) | pix(x1, y1, seed);
        check(tag, act, exp);
        act = {out_valid, out_sync, out_fx, out_fy};
        exp = (1 << 9) | (int'(s) << 8) | (((x * 3 + y) & 15) << 4) | ((x + y * 7) & 15);
        check("R7", act, exp);
    endtask

    // sweep every coordinate; pipelined one read per cycle (R8)
    task automatic sweep(int seed, bit reverse);
        int px, py;
        bit ps, pend;
        pend = 1'b0;
        px = 0; py = 0; ps = 1'b0;
        for (int i = 0; i < W * H; i++) begin
            int k, x, y;
            k = reverse ? (W * H - 1 - i) : i;
            x = k % W;
            y = k / W;
            if (pend) check_window(px, py, ps, seed);
            rd_valid = 1'b1;
            rd_sync  = (i == 0);
            rd_x     = XW'(x);
            rd_y     = YW'(y);
            rd_fx    = FW'((x * 3 + y) & 15);
            rd_fy    = FW'((x + y * 7) & 15);
            px = x; py = y; ps = (i == 0); pend = 1'b1;
            @(negedge clk);
        end
        check_window(px, py, ps, seed);
        rd_valid = 1'b0;
        rd_sync  = 1'b0;
        @(negedge clk);
        check("R8", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'({out_valid, out_sync}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'({out_valid, out_sync}), 0);

        // aborted partial frame, then a restart (R9)
        for (int i = 0; i < 10; i++) put(i == 0, 8'h11);
        write_frame(1);
        check("R8", int'(out_valid), 0);
        // tail without sync after frame end must be dropped (R3)
        for (int i = 0; i < W; i++) put(1'b0, 8'hFF);
        sweep(1, 1'b0);

        // restart in the middle of a full-length frame (R9)
        for (int i = 0; i < W * 5 + 17; i++) put(i == 0, 8'h5C);
        write_frame(2);
        for (int i = 0; i < 9; i++) put(1'b0, 8'h00);
        sweep(2, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule